// File: doc/BRIEF.md
# Millisecond Time Base with Coherent Seconds Snapshot

This block is a free-running time base for a chip that needs a millisecond-resolution timestamp that keeps counting across low-power states. A one-cycle tick pulse at 1 kHz advances a milliseconds counter that cycles through 0..999. Each time that counter wraps, a 32-bit seconds counter advances in the same cycle. The tick source lies outside the block.

Software reads the time through a small read-only register port. A read of the milliseconds register has a side effect: in the same cycle it copies the seconds count into a snapshot register. Software reads milliseconds first and then the snapshot. It forms the timestamp as snapshot × 1000 + milliseconds, and the two halves can never tear across a wrap. The live seconds count can also be read directly, and that read leaves the snapshot alone. The snapshot is one shared register, so two agents whose read pairs interleave can spoil each other's pair.

Each read is sampled on a clock edge. The read data appears on the following cycle and shows each register's value after that edge.

Top module: `msrtc_timebase`

## Requirements
- R1: After reset, the milliseconds count, the seconds count, the snapshot and the read data are all zero.
- R2: Each clock cycle with `tick_i` high adds one to the milliseconds count. Without a tick the count holds.
- R3: A tick while the milliseconds count is 999 sets it to 0 and adds one to the seconds count on the same edge. The seconds count changes at no other time.
- R4: A read at address 0x10 returns the milliseconds count, zero-extended to 32 bits. On the same edge it copies the seconds count into the snapshot.
- R5: When a 0x10 read and a wrapping tick share a cycle, the read returns 0 and the snapshot takes the incremented seconds value.
- R6: A read at address 0x08 returns the live seconds count and leaves the snapshot unchanged.
- R7: A read at address 0x0C returns the snapshot and has no side effect.
- R8: A read at any other address returns zero and leaves the snapshot unchanged.
- R9: `rd_data_o` changes only on the edge after a sampled `rd_en_i`. It then shows the addressed register's value after that edge. Without a read, both `rd_data_o` and the snapshot hold, whatever `rd_addr_i` carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_i | input | 1 | One-cycle 1 kHz count enable |
| rd_en_i | input | 1 | Read strobe, sampled on the rising edge |
| rd_addr_i | input | 5 | Byte address of the register to read |
| rd_data_o | output | 32 | Registered read data |

## Verification
The delicate coincidence is a milliseconds read in the same cycle as the tick that wraps 999 to 0. The snapshot and the returned milliseconds must both show the post-wrap state. The bench provokes this in two ways. It walks the count up to 999 and then issues the read together with the wrapping tick. It also sweeps thousands of ticks while alternating milliseconds and snapshot reads on every cycle, so wraps land under both kinds of read. Each returned pair is judged against a total tick count kept in the bench: milliseconds as the count modulo 1000, seconds as the count divided by 1000.

// File: rtl/msrtc_pkg.sv
package msrtc_pkg;
  localparam int ADDR_W = 5;
  localparam logic [ADDR_W-1:0] ADDR_SEC_LIVE = 5'h08;
  localparam logic [ADDR_W-1:0] ADDR_SEC_SNAP = 5'h0C;
  localparam logic [ADDR_W-1:0] ADDR_MSEC     = 5'h10;
endpackage

// File: rtl/msrtc_rst_sync.sv
module msrtc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_no = sync_q[STAGES-1];
endmodule

// File: rtl/msrtc_ms_counter.sv
module msrtc_ms_counter #(
  parameter int TICKS = 1000,
  parameter int MS_W  = 10
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  output logic [MS_W-1:0] ms_q_o,
  output logic [MS_W-1:0] ms_d_o,
  output logic            wrap_o
);
  localparam logic [MS_W-1:0] LAST = MS_W'(TICKS - 1);

  logic [MS_W-1:0] ms_q, ms_d;
  logic            wrap;

  always_comb begin
    wrap = tick_i && (ms_q == LAST);
    ms_d = ms_q;
    if (tick_i) ms_d = wrap ? '0 : ms_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ms_q <= '0;
    else if (tick_i) ms_q <= ms_d;
  end

  assign ms_q_o = ms_q;
  assign ms_d_o = ms_d;
  assign wrap_o = wrap;
endmodule

// File: rtl/msrtc_sec_counter.sv
module msrtc_sec_counter #(
  parameter int SEC_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  output logic [SEC_W-1:0] sec_q_o,
  output logic [SEC_W-1:0] sec_d_o
);
  logic [SEC_W-1:0] sec_q, sec_d;

  always_comb begin
    sec_d = sec_q;
    if (inc_i) sec_d = sec_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    sec_q <= '0;
    else if (inc_i) sec_q <= sec_d;
  end

  assign sec_q_o = sec_q;
  assign sec_d_o = sec_d;
endmodule

// File: rtl/msrtc_regs.sv
module msrtc_regs
  import msrtc_pkg::*;
#(
  parameter int MS_W   = 10,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [MS_W-1:0]   ms_d_i,
  input  logic [DATA_W-1:0] sec_d_i,
  output logic [DATA_W-1:0] snap_q_o,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [DATA_W-1:0] snap_q, snap_d, rdat_q, rdat_d;
  logic              sel_ms, snap_en;

  always_comb begin
    sel_ms  = rd_en_i && (rd_addr_i == ADDR_MSEC);
    snap_en = sel_ms;
    snap_d  = sec_d_i;
    unique case (rd_addr_i)
      ADDR_MSEC:     rdat_d = {{(DATA_W-MS_W){1'b0}}, ms_d_i};
      ADDR_SEC_LIVE: rdat_d = sec_d_i;
      ADDR_SEC_SNAP: rdat_d = snap_q;
      default:       rdat_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      snap_q <= '0;
    else if (snap_en) snap_q <= snap_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdat_q <= '0;
    else if (rd_en_i) rdat_q <= rdat_d;
  end

  assign snap_q_o  = snap_q;
  assign rd_data_o = rdat_q;
endmodule

// File: rtl/msrtc_timebase.sv
module msrtc_timebase
  import msrtc_pkg::*;
#(
  parameter int TICKS_PER_SEC = 1000,
  parameter int SEC_W         = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [SEC_W-1:0]  rd_data_o
);
  localparam int MS_W = $clog2(TICKS_PER_SEC);

  logic             rst_s_n;
  logic [MS_W-1:0]  ms_q, ms_d;
  logic             wrap;
  logic [SEC_W-1:0] sec_q, sec_d, snap_q;

  msrtc_rst_sync #(.STAGES(2)) u_rst (
    .clk_i(clk_i), .rst_ni(rst_ni), .rst_sync_no(rst_s_n)
  );

  msrtc_ms_counter #(.TICKS(TICKS_PER_SEC), .MS_W(MS_W)) u_ms (
    .clk_i(clk_i), .rst_ni(rst_s_n), .tick_i(tick_i),
    .ms_q_o(ms_q), .ms_d_o(ms_d), .wrap_o(wrap)
  );

  msrtc_sec_counter #(.SEC_W(SEC_W)) u_sec (
    .clk_i(clk_i), .rst_ni(rst_s_n), .inc_i(wrap),
    .sec_q_o(sec_q), .sec_d_o(sec_d)
  );

  msrtc_regs #(.MS_W(MS_W), .DATA_W(SEC_W)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_s_n), .rd_en_i(rd_en_i), .rd_addr_i(rd_addr_i),
    .ms_d_i(ms_d), .sec_d_i(sec_d), .snap_q_o(snap_q), .rd_data_o(rd_data_o)
  );
endmodule

// File: rtl/msrtc_chk.sv
module msrtc_chk
  import msrtc_pkg::*;
#(
  parameter int TICKS_PER_SEC = 1000,
  parameter int SEC_W         = 32,
  parameter int MS_W          = 10
) (
  input logic              clk_i,
  input logic              rst_s_n,
  input logic              tick_i,
  input logic              rd_en_i,
  input logic [ADDR_W-1:0] rd_addr_i,
  input logic [MS_W-1:0]   ms_q,
  input logic [SEC_W-1:0]  sec_q,
  input logic [SEC_W-1:0]  snap_q,
  input logic [SEC_W-1:0]  rd_data_o
);
  localparam logic [MS_W-1:0] LAST = MS_W'(TICKS_PER_SEC - 1);

  // R2
  ms_step_chk: assert property (@(posedge clk_i) disable iff (!rst_s_n)
    (tick_i && ms_q != LAST) |=> (ms_q == $past(ms_q) + 1'b1));
  // R2
  ms_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_s_n)
    !tick_i |=> $stable(ms_q));
  // R3
  ms_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_s_n)
    (tick_i && ms_q == LAST) |=> (ms_q == '0 && sec_q == $past(sec_q) + 1'b1));
  // R3
  sec_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_s_n)
    !(tick_i && ms_q == LAST) |=> $stable(sec_q));
  // R5
  snap_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_s_n)
    (rd_en_i && rd_addr_i == ADDR_MSEC) |=> (snap_q == sec_q));
  // R6
  snap_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_s_n)
    !(rd_en_i && rd_addr_i == ADDR_MSEC) |=> $stable(snap_q));
  // R9
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_s_n)
    !rd_en_i |=> $stable(rd_data_o));
  // R8
  rdata_unmapped_chk: assert property (@(posedge clk_i) disable iff (!rst_s_n)
    (rd_en_i && rd_addr_i != ADDR_MSEC && rd_addr_i != ADDR_SEC_LIVE &&
     rd_addr_i != ADDR_SEC_SNAP) |=> (rd_data_o == '0));
endmodule

bind msrtc_timebase msrtc_chk #(
  .TICKS_PER_SEC(TICKS_PER_SEC), .SEC_W(SEC_W), .MS_W(MS_W)
) u_chk (
  .clk_i(clk_i), .rst_s_n(rst_s_n), .tick_i(tick_i), .rd_en_i(rd_en_i),
  .rd_addr_i(rd_addr_i), .ms_q(ms_q), .sec_q(sec_q), .snap_q(snap_q),
  .rd_data_o(rd_data_o)
);

// File: tb/tb_msrtc_timebase.sv
module tb_msrtc_timebase;
  import msrtc_pkg::*;

  logic              clk_i = 1'b0;
  logic              rst_ni;
  logic              tick_i;
  logic              rd_en_i;
  logic [ADDR_W-1:0] rd_addr_i;
  logic [31:0]       rd_data_o;

  int    checks = 0;
  int    errs   = 0;
  int    total  = 0;
  int    snap_exp = 0;
  bit    done   = 0;

  always #5 clk_i = ~clk_i;

  msrtc_timebase dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i),
    .rd_en_i(rd_en_i), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input bit t, input bit r, input logic [ADDR_W-1:0] a);
    tick_i = t; rd_en_i = r; rd_addr_i = a;
    @(posedge clk_i);
    if (t) total++;
    if (r && a == ADDR_MSEC) snap_exp = total / 1000;
    @(negedge clk_i);
    tick_i = 1'b0; rd_en_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      errs++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errs);
      $finish;
    end
  end

  initial begin
    int saved;
    logic [31:0] held;
    rst_ni = 1'b0; tick_i = 1'b0; rd_en_i = 1'b0; rd_addr_i = '0;
    repeat (4) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);

    chk("R1 rd_data after reset", rd_data_o, 32'd0);
    cyc(0, 1, ADDR_SEC_SNAP); chk("R1 snapshot", rd_data_o, 32'd0);
    cyc(0, 1, ADDR_SEC_LIVE); chk("R1 seconds", rd_data_o, 32'd0);
    cyc(0, 1, ADDR_MSEC);     chk("R1 milliseconds", rd_data_o, 32'd0);

    // R2 R3 R4 R7 sweep: tick every cycle, alternate ms and snapshot reads
    for (int i = 0; i < 2600; i++) begin
      if (i % 2 == 0) begin
        cyc(1, 1, ADDR_MSEC);
        chk("R2/R3/R4 ms read", rd_data_o, 32'(total % 1000));
      end else begin
        cyc(1, 1, ADDR_SEC_SNAP);
        chk("R4/R7 snapshot read", rd_data_o, 32'(snap_exp));
      end
    end

    // R2 hold without tick
    for (int i = 0; i < 3; i++) begin
      cyc(0, 1, ADDR_MSEC);
      chk("R2 hold without tick", rd_data_o, 32'(total % 1000));
    end

    // R5: milliseconds read coinciding with the wrapping tick
    while (total % 1000 != 998) cyc(1, 0, ADDR_SEC_LIVE);
    cyc(1, 1, ADDR_SEC_LIVE); chk("R3 seconds before wrap", rd_data_o, 32'(total / 1000));
    cyc(1, 1, ADDR_MSEC);     chk("R5 ms on wrap read", rd_data_o, 32'd0);
    cyc(0, 1, ADDR_SEC_SNAP); chk("R5 snapshot post-wrap", rd_data_o, 32'(total / 1000));
    chk("R5 snapshot model", rd_data_o, 32'(snap_exp));

    // R6: live seconds read leaves snapshot alone
    cyc(0, 1, ADDR_MSEC);
    saved = total / 1000;
    for (int i = 0; i < 1500; i++) cyc(1, 0, ADDR_SEC_LIVE);
    cyc(0, 1, ADDR_SEC_LIVE); chk("R6 live seconds", rd_data_o, 32'(total / 1000));
    cyc(0, 1, ADDR_SEC_LIVE); chk("R6 live seconds repeat", rd_data_o, 32'(total / 1000));
    cyc(0, 1, ADDR_SEC_SNAP); chk("R6/R7 snapshot unchanged", rd_data_o, 32'(saved));
    chk("R6 seconds moved past snapshot", 32'(total / 1000 != saved), 32'd1);

    // R8: unmapped addresses
    cyc(1, 1, 5'h04); chk("R8 addr 0x04", rd_data_o, 32'd0);
    cyc(1, 1, 5'h14); chk("R8 addr 0x14", rd_data_o, 32'd0);
    cyc(1, 1, 5'h00); chk("R8 addr 0x00", rd_data_o, 32'd0);
    cyc(0, 1, ADDR_SEC_SNAP); chk("R8 snapshot unchanged", rd_data_o, 32'(saved));

    // R9: no read strobe, address on ms: data and snapshot hold
    cyc(0, 1, ADDR_MSEC);
    held = rd_data_o;
    saved = snap_exp;
    for (int i = 0; i < 1200; i++) begin
      cyc(1, 0, ADDR_MSEC);
      if (i % 100 == 0) chk("R9 rd_data holds", rd_data_o, held);
    end
    cyc(0, 1, ADDR_SEC_SNAP); chk("R9 snapshot held without strobe", rd_data_o, 32'(saved));
    cyc(0, 1, ADDR_MSEC);     chk("R9/R4 ms after idle", rd_data_o, 32'(total % 1000));

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end
endmodule